// File: doc/BRIEF.md
# Link Training Bring-Up Monitor

This block brings up a serial link and watches it train. When software or a sequencer pulses `startReq`, the block raises the training-enable output. It then goes through three gated waits. First it waits for the physical-layer link-up flag. Next it waits for the data-link-layer link-up flag. After both flags are seen, it fires a one-cycle directed speed-change request. Last, it waits for the training state code to fall inside the operational window.

Each wait samples its condition on a poll tick, once every `POLL_CYC` clock cycles. A wait gives up after `TIMEOUT_POLLS` samples that all failed. On a timeout the block reports a 2-bit code that names the phase that failed, and it leaves the enable asserted. A `stopReq` pulse drops the enable and returns the block to idle from any state. The defaults model a poll every 1 ms at 100 MHz and a 1 s limit. In simulation both can be made much shorter.

Top module: `lnkmon_top`

## Requirements
- R1: After reset, `ltssmEn`, `speedChgReq`, `linkUp` and `timedOut` are 0, and `failPhase` is 2'b00.
- R2: A `startReq` seen while idle raises `ltssmEn` at the next clock edge. `ltssmEn` then stays 1 in every later state, including linked-up and timed-out, until a stop.
- R3: The data-link flag `dllUp` is only examined after `phyUp` has been accepted. With `phyUp` low, no value of `dllUp` leads to a speed-change request.
- R4: Each wait samples its condition once every `POLL_CYC` cycles. The first sample comes `POLL_CYC` cycles after the wait is entered. The wait is left at the edge that ends a cycle whose sample was true, so a condition that becomes true after an earlier failed sample is accepted on the following poll.
- R5: `speedChgReq` is high for exactly one cycle. It rises 2*`POLL_CYC` cycles after start when both flags are already up, and it only occurs after both flags were accepted.
- R6: The link counts as operational only for `ltssmState` codes 6'h11 to 6'h16 inclusive. `linkUp` rises `POLL_CYC` cycles after the speed-change cycle when the code is in that window. Codes 6'h10, 6'h17 and 6'h20 are not operational.
- R7: A wait whose `TIMEOUT_POLLS` samples all fail sets `timedOut`. It also sets `failPhase` to 1 (physical link), 2 (data link) or 3 (operational window). Otherwise `timedOut` is 0 and `failPhase` is 0.
- R8: A `stopReq` in any state clears `ltssmEn`, `linkUp`, `timedOut` and `failPhase` at the next edge. It wins over a `startReq` that arrives in the same cycle.
- R9: A `startReq` outside the idle state is ignored. It causes no speed-change request and leaves `linkUp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin bring-up (honoured when idle) |
| stopReq | input | 1 | Drop training enable, return to idle |
| ltssmState | input | STATE_W | Current training state code |
| phyUp | input | 1 | Physical-layer link-up flag |
| dllUp | input | 1 | Data-link-layer link-up flag |
| ltssmEn | output | 1 | Training enable |
| speedChgReq | output | 1 | One-cycle directed speed-change request |
| linkUp | output | 1 | Bring-up completed, link operational |
| timedOut | output | 1 | A wait phase ran out of polls |
| failPhase | output | 2 | Phase that timed out (1, 2, 3), else 0 |

## Verification
Take the start-accepting edge as edge 0. With both flags already up, the physical wait ends at edge `POLL_CYC` and the speed-change pulse follows at edge 2*`POLL_CYC`. `linkUp` then rises at edge 3*`POLL_CYC`+1. A timeout in the first phase lands at edge `TIMEOUT_POLLS`*`POLL_CYC`. Phases 2 and 3 are offset by `POLL_CYC` and by 2*`POLL_CYC`+1 respectively. The bench drives inputs on falling edges and counts edges from edge 0. At each due edge it samples once on the falling edge just before it, to see the old value, and once just after it, to see the new value. A stop takes effect one edge after it is applied.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_PHY,
    ST_WAIT_DLL,
    ST_KICK,
    ST_WAIT_OPER,
    ST_UP,
    ST_FAIL
  } lnkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       clrCnt;
    logic       run;
    logic       latchFail;
    logic       clrFail;
    logic [1:0] failCode;
  } lnkStrobe_t;

  localparam logic [1:0] FAIL_NONE = 2'd0;
  localparam logic [1:0] FAIL_PHY  = 2'd1;
  localparam logic [1:0] FAIL_DLL  = 2'd2;
  localparam logic [1:0] FAIL_OPER = 2'd3;

endpackage

// File: rtl/lnkmon_dp.sv
module lnkmon_dp
  import lnkmon_pkg::*;
#(
  parameter int POLL_CYC      = 100000,
  parameter int TIMEOUT_POLLS = 1000,
  parameter int STATE_W       = 6,
  parameter int WIN_LO        = 'h11,
  parameter int WIN_HI        = 'h16
) (
  input  logic               clk,
  input  logic               rstN,
  input  lnkStrobe_t         strb,
  input  logic [STATE_W-1:0] ltssmState,
  output logic               pollTick,
  output logic               lastPoll,
  output logic               inWindow,
  output logic [1:0]         failPhase
);

  localparam int PCW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int TCW = (TIMEOUT_POLLS > 1) ? $clog2(TIMEOUT_POLLS) : 1;
  localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_CYC - 1);
  localparam logic [TCW-1:0] TICK_LAST = TCW'(TIMEOUT_POLLS - 1);
  localparam logic [STATE_W-1:0] LO = STATE_W'(WIN_LO);
  localparam logic [STATE_W-1:0] HI = STATE_W'(WIN_HI);

  logic [PCW-1:0] pollCnt;
  logic [TCW-1:0] tickCnt;
  logic [1:0]     failReg;

  assign pollTick = strb.run && (pollCnt == POLL_LAST);
  assign lastPoll = pollTick && (tickCnt == TICK_LAST);
  assign inWindow = (ltssmState >= LO) && (ltssmState <= HI);
  assign failPhase = failReg;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrCnt) begin
      pollCnt <= '0;
      tickCnt <= '0;
    end else if (strb.run) begin
      if (pollCnt == POLL_LAST) begin
        pollCnt <= '0;
        tickCnt <= tickCnt + 1'b1;
      end else begin
        pollCnt <= pollCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrFail) begin
      failReg <= FAIL_NONE;
    end else if (strb.latchFail) begin
      failReg <= strb.failCode;
    end
  end

endmodule

// File: rtl/lnkmon_ctrl.sv
module lnkmon_ctrl
  import lnkmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       phyUp,
  input  logic       dllUp,
  input  logic       pollTick,
  input  logic       lastPoll,
  input  logic       inWindow,
  output lnkStrobe_t strb,
  output logic       ltssmEn,
  output logic       speedChgReq,
  output logic       linkUp,
  output logic       timedOut
);

  lnkState_e st, stNxt;

  always_comb begin
    stNxt = st;
    strb  = '0;
    unique case (st)
      ST_IDLE: begin
        if (startReq) begin
          stNxt        = ST_WAIT_PHY;
          strb.clrCnt  = 1'b1;
          strb.clrFail = 1'b1;
        end
      end
      ST_WAIT_PHY: begin
        strb.run = 1'b1;
        if (pollTick && phyUp) begin
          stNxt       = ST_WAIT_DLL;
          strb.clrCnt = 1'b1;
        end else if (lastPoll) begin
          stNxt          = ST_FAIL;
          strb.latchFail = 1'b1;
          strb.failCode  = FAIL_PHY;
        end
      end
      ST_WAIT_DLL: begin
        strb.run = 1'b1;
        if (pollTick && dllUp) begin
          stNxt       = ST_KICK;
          strb.clrCnt = 1'b1;
        end else if (lastPoll) begin
          stNxt          = ST_FAIL;
          strb.latchFail = 1'b1;
          strb.failCode  = FAIL_DLL;
        end
      end
      ST_KICK: begin
        stNxt       = ST_WAIT_OPER;
        strb.clrCnt = 1'b1;
      end
      ST_WAIT_OPER: begin
        strb.run = 1'b1;
        if (pollTick && inWindow) begin
          stNxt = ST_UP;
        end else if (lastPoll) begin
          stNxt          = ST_FAIL;
          strb.latchFail = 1'b1;
          strb.failCode  = FAIL_OPER;
        end
      end
      ST_UP:   stNxt = ST_UP;
      ST_FAIL: stNxt = ST_FAIL;
      default: stNxt = ST_IDLE;
    endcase
    if (stopReq) begin
      stNxt        = ST_IDLE;
      strb         = '0;
      strb.clrFail = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNxt;
  end

  assign ltssmEn     = (st != ST_IDLE);
  assign speedChgReq = (st == ST_KICK);
  assign linkUp      = (st == ST_UP);
  assign timedOut    = (st == ST_FAIL);

endmodule

// File: rtl/lnkmon_top.sv
module lnkmon_top
  import lnkmon_pkg::*;
#(
  parameter int POLL_CYC      = 100000,
  parameter int TIMEOUT_POLLS = 1000,
  parameter int STATE_W       = 6,
  parameter int WIN_LO        = 'h11,
  parameter int WIN_HI        = 'h16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               stopReq,
  input  logic [STATE_W-1:0] ltssmState,
  input  logic               phyUp,
  input  logic               dllUp,
  output logic               ltssmEn,
  output logic               speedChgReq,
  output logic               linkUp,
  output logic               timedOut,
  output logic [1:0]         failPhase
);

  lnkStrobe_t strb;
  logic pollTick, lastPoll, inWindow;

  lnkmon_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .phyUp(phyUp), .dllUp(dllUp), .pollTick(pollTick), .lastPoll(lastPoll),
    .inWindow(inWindow), .strb(strb), .ltssmEn(ltssmEn),
    .speedChgReq(speedChgReq), .linkUp(linkUp), .timedOut(timedOut)
  );

  lnkmon_dp #(
    .POLL_CYC(POLL_CYC), .TIMEOUT_POLLS(TIMEOUT_POLLS), .STATE_W(STATE_W),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .ltssmState(ltssmState),
    .pollTick(pollTick), .lastPoll(lastPoll), .inWindow(inWindow),
    .failPhase(failPhase)
  );

endmodule

// File: rtl/lnkmon_chk.sv
module lnkmon_chk #(
  parameter int STATE_W = 6,
  parameter int WIN_LO  = 'h11,
  parameter int WIN_HI  = 'h16
) (
  input logic               clk,
  input logic               rstN,
  input logic               stopReq,
  input logic [STATE_W-1:0] ltssmState,
  input logic               dllUp,
  input logic               ltssmEn,
  input logic               speedChgReq,
  input logic               linkUp,
  input logic               timedOut,
  input logic [1:0]         failPhase
);

  // R5
  kick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    speedChgReq |=> !speedChgReq);

  // R5
  kick_after_dll_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(speedChgReq) |-> $past(dllUp));

  // R2
  en_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timedOut || linkUp || speedChgReq) |-> ltssmEn);

  // R8
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> (!ltssmEn && failPhase == 2'd0));

  // R7
  fail_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |-> (failPhase != 2'd0));

  // R7
  no_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    !timedOut |-> (failPhase == 2'd0));

  // R6
  up_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkUp) |-> ($past(ltssmState) >= STATE_W'(WIN_LO) &&
                       $past(ltssmState) <= STATE_W'(WIN_HI)));

  // R7
  up_xor_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(linkUp && timedOut));

endmodule

bind lnkmon_top lnkmon_chk #(.STATE_W(STATE_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) chk_i (
  .clk(clk), .rstN(rstN), .stopReq(stopReq), .ltssmState(ltssmState),
  .dllUp(dllUp), .ltssmEn(ltssmEn), .speedChgReq(speedChgReq),
  .linkUp(linkUp), .timedOut(timedOut), .failPhase(failPhase)
);

// File: tb/lnkmon_tb.sv
module lnkmon_top_tb_top;

  localparam int P = 4;
  localparam int T = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, stopReq = 1'b0, phyUp = 1'b0, dllUp = 1'b0;
  logic [5:0] ltssmState = 6'h00;
  logic ltssmEn, speedChgReq, linkUp, timedOut;
  logic [1:0] failPhase;

  int nChk = 0, nBad = 0, at = 0;

  always #5 clk = ~clk;

  lnkmon_top #(.POLL_CYC(P), .TIMEOUT_POLLS(T)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .ltssmState(ltssmState), .phyUp(phyUp), .dllUp(dllUp),
    .ltssmEn(ltssmEn), .speedChgReq(speedChgReq), .linkUp(linkUp),
    .timedOut(timedOut), .failPhase(failPhase)
  );

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, at, act, exp);
    end
  endtask

  task automatic startRun();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    at = 0;
  endtask

  task automatic waitTo(int n);
    while (at < n) begin
      @(negedge clk);
      at++;
    end
  endtask

  task automatic stopRun();
    @(negedge clk) stopReq = 1'b1;
    @(negedge clk) stopReq = 1'b0;
    at++;
    check("R8 en", ltssmEn, 0);
    check("R8 up", linkUp, 0);
    check("R8 to", timedOut, 0);
    check("R8 code", failPhase, 0);
  endtask

  task automatic tResetState();
    check("R1 en", ltssmEn, 0);
    check("R1 kick", speedChgReq, 0);
    check("R1 up", linkUp, 0);
    check("R1 to", timedOut, 0);
    check("R1 code", failPhase, 0);
  endtask

  task automatic tHappy();
    phyUp = 1; dllUp = 1; ltssmState = 6'h11;
    startRun();
    check("R2 en", ltssmEn, 1);
    waitTo(2*P-1); check("R5 early", speedChgReq, 0);
    waitTo(2*P);   check("R5 kick", speedChgReq, 1);
    waitTo(2*P+1); check("R5 one cycle", speedChgReq, 0);
    waitTo(3*P);   check("R6 not yet", linkUp, 0);
    waitTo(3*P+1); check("R6 up", linkUp, 1);
    check("R7 no timeout", timedOut, 0);
    // R9: start while linked up is ignored
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    at += 2;
    waitTo(at + 2*P + 2);
    check("R9 up kept", linkUp, 1);
    check("R9 no kick", speedChgReq, 0);
    check("R2 en up", ltssmEn, 1);
    stopRun();
  endtask

  task automatic tPhyTimeout();
    phyUp = 0; dllUp = 1; ltssmState = 6'h11;
    startRun();
    waitTo(T*P-1); check("R7 p1 early", timedOut, 0);
    check("R3 no kick", speedChgReq, 0);
    waitTo(T*P);   check("R7 p1 to", timedOut, 1);
    check("R7 p1 code", failPhase, 1);
    waitTo(T*P+10); check("R2 en after to", ltssmEn, 1);
    check("R7 p1 held", failPhase, 1);
    stopRun();
  endtask

  task automatic tDllTimeout();
    phyUp = 1; dllUp = 0;
    startRun();
    waitTo(P+T*P-1); check("R7 p2 early", timedOut, 0);
    waitTo(P+T*P);   check("R7 p2 to", timedOut, 1);
    check("R7 p2 code", failPhase, 2);
    check("R5 no kick p2", speedChgReq, 0);
    stopRun();
  endtask

  task automatic tOperFail(logic [5:0] code);
    phyUp = 1; dllUp = 1; ltssmState = code;
    startRun();
    waitTo(2*P); check("R5 kick p3", speedChgReq, 1);
    waitTo(2*P+1+T*P-1); check("R6 out window", linkUp, 0);
    check("R7 p3 early", timedOut, 0);
    waitTo(2*P+1+T*P); check("R7 p3 to", timedOut, 1);
    check("R7 p3 code", failPhase, 3);
    check("R6 not up", linkUp, 0);
    stopRun();
  endtask

  task automatic tWindowTop();
    phyUp = 1; dllUp = 1; ltssmState = 6'h16;
    startRun();
    waitTo(3*P+1); check("R6 top edge", linkUp, 1);
    stopRun();
  endtask

  task automatic tLatePhy();
    phyUp = 0; dllUp = 1; ltssmState = 6'h11;
    startRun();
    waitTo(P); check("R4 still phy", speedChgReq, 0);
    waitTo(5); phyUp = 1;
    waitTo(3*P-1); check("R4 late kick early", speedChgReq, 0);
    waitTo(3*P);   check("R4 late kick", speedChgReq, 1);
    waitTo(4*P+1); check("R4 late up", linkUp, 1);
    stopRun();
  endtask

  task automatic tStopMid();
    phyUp = 1; dllUp = 1; ltssmState = 6'h11;
    startRun();
    waitTo(2);
    stopRun();
    waitTo(at + 4*P);
    check("R8 stays idle en", ltssmEn, 0);
    check("R8 stays idle up", linkUp, 0);
    // R8: stop wins over simultaneous start
    @(negedge clk) begin startReq = 1'b1; stopReq = 1'b1; end
    @(negedge clk) begin startReq = 1'b0; stopReq = 1'b0; end
    check("R8 stop priority", ltssmEn, 0);
  endtask

  initial begin
    #2_000_000;
    nChk++; nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tHappy();
    tPhyTimeout();
    tDllTimeout();
    tOperFail(6'h20);
    tOperFail(6'h10);
    tOperFail(6'h17);
    tWindowTop();
    tLatePhy();
    tStopMid();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule